// File: doc/BRIEF.md
# Byte-Wide Link Port Transmitter

This block streams 16-byte quad-words to a downstream receiver over an 8-bit data bus, with a forwarded clock beside it. Quad-words come in on a valid/ready interface. The receiver controls the flow through a single ready line. When that line goes high while the block is idle, the block waits for a programmable number of parallel-clock cycles. It then starts sending bytes, and the forwarded clock toggles with every byte.

A transfer can be followed by the next one with no gap. For this, the receiver pulses its ready line low and then high again while the current quad-word is still being sent. If the receiver gives no such pulse, the block goes back to idle after the last byte. The next transfer then needs a new request and the full wait again.

Two small configuration fields are also held here: a clock-source select and a payload mode. The block flags the payload mode combination that is invalid.

Top module: `lnk_tx`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after reset, `lclk_o`, `ldat_o`, `qw_ready_o`, `mode_err_o` and `clk_int_o` are all 0.
- R2: Each accepted quad-word is sent as 16 bytes, least significant byte first (byte k is `qw_data_i[8k+7:8k]`), one byte per clock cycle. `lclk_o` is 1 on even byte indices and 0 on odd ones, so it toggles with every byte. `lclk_o` and `ldat_o` are 0 whenever no byte is being sent.
- R3: From idle, if `rdy_i` is sampled high at clock edge E and a quad-word is offered, byte 0 appears on the outputs after edge E+W. W is the value of `cfg_wait_i`.
- R4: A `cfg_wait_i` value below 6 is treated as 6.
- R5: Suppose that during a transfer `rdy_i` is sampled low and later sampled high, both while byte indices 0 to 14 are on the bus, and the next quad-word is offered. Then that quad-word's byte 0 follows byte 15 in the very next cycle.
- R6: If no low-then-high pulse is seen during a transfer, the block returns to idle after byte 15. With `rdy_i` held high, the next byte 0 comes W+2 cycles after the previous byte 15.
- R7: If a transfer is permitted but no quad-word is offered, `qw_ready_o` stays 1 and `lclk_o` and `ldat_o` stay 0. Byte 0 then appears one cycle after the edge that accepts the quad-word, and a pending pulse is kept until that happens.
- R8: `mode_err_o` is 1 in the cycle after the edge at which `cfg_mode_i` equals 3'b101 (bit 0 = 1, bit 1 = 0, bit 2 = 1), and 0 after any other value.
- R9: `clk_int_o` is a registered copy of `cfg_clksrc_i`. It resets to 0, which means the parallel clock is supplied externally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qw_data_i | input | 128 | Quad-word to send |
| qw_valid_i | input | 1 | Quad-word offered |
| qw_ready_o | output | 1 | Quad-word accepted at this edge if it is offered |
| rdy_i | input | 1 | Receiver ready line |
| cfg_wait_i | input | 4 | Pre-transfer wait in cycles (minimum 6) |
| cfg_mode_i | input | 3 | Payload mode field |
| cfg_clksrc_i | input | 1 | Clock source select: 0 external, 1 internal |
| lclk_o | output | 1 | Forwarded clock, idles low |
| ldat_o | output | 8 | Byte bus |
| mode_err_o | output | 1 | Invalid payload mode flag |
| clk_int_o | output | 1 | Registered clock source select |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 16 bytes per quad-word, a 4-bit wait field and a minimum wait of 6. With a 4-bit field, the whole range of programmed waits can be reached. The bench uses waits of 8 and 15, and a value of 2 to exercise the lower clamp. The short quad-word keeps each transfer at 16 cycles. This makes the back-to-back case, the return to idle and the held-permit case cheap enough to run each one separately after its own reset.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_XFER = 2'd2} lnk_st_e;
  localparam logic [2:0] MODE_BAD = 3'b101;
endpackage

// File: rtl/lnk_tx_wait.sv
module lnk_tx_wait #(
  parameter int WAIT_W   = 4,
  parameter int MIN_WAIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              sat_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  output logic              done_o
);
  localparam int CW = WAIT_W + 1;

  logic [CW-1:0] cnt_q, lim;
  logic          sat_q;

  assign lim    = (CW'(cfg_wait_i) < CW'(MIN_WAIT)) ? CW'(MIN_WAIT) : CW'(cfg_wait_i);
  assign done_o = sat_q || (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (sat_i) begin
      sat_q <= 1'b1;
    end else if (en_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_tx_chk.sv
module lnk_tx_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic rdy_i,
  output logic seen_o
);
  logic low_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      low_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (en_i) begin
      if (!rdy_i) low_q <= 1'b1;
      if (rdy_i && low_q) seen_q <= 1'b1;
    end
  end

  assign seen_o = seen_q;

  assert_seen_after_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen_q) |-> $past(rdy_i));
endmodule

// File: rtl/lnk_tx_ser.sv
module lnk_tx_ser #(
  parameter int DW = 8,
  parameter int NB = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [NB*DW-1:0] data_i,
  output logic            lclk_o,
  output logic [DW-1:0]   ldat_o,
  output logic            last_o
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB*DW-1:0] sh_q;
  logic [IW-1:0]    idx_q;
  logic             act_q, lclk_q;
  logic [DW-1:0]    dat_q;

  assign last_o = act_q && (idx_q == IW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      lclk_q <= 1'b0;
      dat_q  <= '0;
    end else if (load_i) begin
      sh_q   <= data_i >> DW;
      dat_q  <= data_i[DW-1:0];
      lclk_q <= 1'b1;
      idx_q  <= '0;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (last_o) begin
        act_q  <= 1'b0;
        lclk_q <= 1'b0;
        dat_q  <= '0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        dat_q  <= sh_q[DW-1:0];
        sh_q   <= sh_q >> DW;
        lclk_q <= ~lclk_q;
      end
    end
  end

  assign lclk_o = lclk_q;
  assign ldat_o = dat_q;

  assert_clock_toggles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q)) |-> (lclk_q != $past(lclk_q)));
endmodule

// File: rtl/lnk_tx.sv
module lnk_tx
  import lnk_tx_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NB       = 16,
  parameter int WAIT_W   = 4,
  parameter int MIN_WAIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB*DW-1:0]  qw_data_i,
  input  logic              qw_valid_i,
  output logic              qw_ready_o,
  input  logic              rdy_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              cfg_clksrc_i,
  output logic              lclk_o,
  output logic [DW-1:0]     ldat_o,
  output logic              mode_err_o,
  output logic              clk_int_o
);
  lnk_st_e st_q, st_d;
  logic    wait_done, seen, ser_last, load;
  logic    mode_err_q, clk_int_q;

  assign qw_ready_o = ((st_q == ST_WAIT) && wait_done) || (ser_last && seen);
  assign load       = qw_valid_i && qw_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rdy_i) st_d = ST_WAIT;
      ST_WAIT: if (load) st_d = ST_XFER;
      ST_XFER: if (ser_last) st_d = load ? ST_XFER : (seen ? ST_WAIT : ST_IDLE);
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_err_q <= 1'b0;
      clk_int_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      mode_err_q <= (cfg_mode_i == MODE_BAD);
      clk_int_q  <= cfg_clksrc_i;
    end
  end

  assign mode_err_o = mode_err_q;
  assign clk_int_o  = clk_int_q;

  lnk_tx_wait #(.WAIT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (st_q == ST_IDLE),
    .en_i      (st_q == ST_WAIT),
    .sat_i     (ser_last && seen && !qw_valid_i),
    .cfg_wait_i(cfg_wait_i),
    .done_o    (wait_done)
  );

  lnk_tx_chk u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .en_i  (st_q == ST_XFER),
    .rdy_i (rdy_i),
    .seen_o(seen)
  );

  lnk_tx_ser #(.DW(DW), .NB(NB)) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(qw_data_i),
    .lclk_o(lclk_o),
    .ldat_o(ldat_o),
    .last_o(ser_last)
  );

  assert_accept_byte0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qw_valid_i && qw_ready_o) |=> (lclk_o && (ldat_o == $past(qw_data_i[DW-1:0]))));
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_XFER) |-> (!lclk_o && (ldat_o == '0)));
  assert_no_early_permit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WAIT) && ($past(st_q) == ST_IDLE)) |-> !qw_ready_o);
  assert_mode_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_BAD) |=> mode_err_o);
endmodule

// File: tb/lnk_tx_test.sv
module lnk_tx_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] qw_data = '0;
  logic         qw_valid = 1'b0;
  logic         qw_ready;
  logic         rdy = 1'b0;
  logic [3:0]   cfg_wait = 4'd6;
  logic [2:0]   cfg_mode = 3'b000;
  logic         cfg_clksrc = 1'b0;
  logic         lclk;
  logic [7:0]   ldat;
  logic         mode_err, clk_int;

  int errors = 0, checks = 0, cyc = 0, bcnt = 0, sent_cyc = 0, t0 = 0;
  logic lclk_prev = 1'b0;
  logic [7:0] exp_q[$];
  int start_q[$], end_q[$];

  localparam logic [127:0] QA = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] QB = 128'hf1e2d3c4b5a69788796a5b4c3d2e1f00;

  lnk_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .qw_data_i(qw_data), .qw_valid_i(qw_valid),
    .qw_ready_o(qw_ready), .rdy_i(rdy), .cfg_wait_i(cfg_wait), .cfg_mode_i(cfg_mode),
    .cfg_clksrc_i(cfg_clksrc), .lclk_o(lclk), .ldat_o(ldat), .mode_err_o(mode_err),
    .clk_int_o(clk_int)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: every forwarded-clock toggle carries one byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (lclk != lclk_prev) begin
        if (exp_q.size() == 0) chk("R2 unexpected byte", int'(ldat), -1);
        else chk("R2 byte", int'(ldat), int'(exp_q.pop_front()));
        chk("R2 clock level", int'(lclk), ((bcnt % 16) % 2 == 0) ? 1 : 0);
        if (bcnt % 16 == 0) start_q.push_back(cyc);
        if (bcnt % 16 == 15) end_q.push_back(cyc);
        bcnt++;
      end
      lclk_prev = lclk;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rdy = 1'b0; qw_valid = 1'b0; cfg_mode = 3'b000; cfg_clksrc = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.delete(); start_q.delete(); end_q.delete();
    bcnt = 0; lclk_prev = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic send_qw(input logic [127:0] d, input bit hold);
    @(negedge clk);
    qw_data = d; qw_valid = 1'b1; sent_cyc = cyc;
    while (!qw_ready) @(negedge clk);
    for (int k = 0; k < 16; k++) exp_q.push_back(d[k*8 +: 8]);
    @(negedge clk);
    if (!hold) qw_valid = 1'b0;
  endtask

  task automatic rdy_pulse();
    wait (lclk == 1'b1);
    repeat (2) @(negedge clk);
    rdy = 1'b0;
    repeat (2) @(negedge clk);
    rdy = 1'b1;
  endtask

  task automatic wait_bytes(input int n);
    while (bcnt < n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_test(input logic [3:0] w, input int exp_d, input string req);
    do_reset();
    cfg_wait = w;
    fork
      send_qw(QA, 1'b0);
      begin @(negedge clk); rdy = 1'b1; t0 = cyc; end
    join
    wait_bytes(16);
    chk(req, start_q[0] - t0, exp_d);
    chk("R2 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 lclk", int'(lclk), 0);
    chk("R1 ldat", int'(ldat), 0);
    chk("R1 ready", int'(qw_ready), 0);
    chk("R1 mode_err", int'(mode_err), 0);
    chk("R1 clk_int", int'(clk_int), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lclk after release", int'(lclk), 0);

    // R3 programmed waits, R4 clamp
    wait_test(4'd8, 9, "R3 wait 8");
    wait_test(4'd15, 16, "R3 wait 15");
    wait_test(4'd2, 7, "R4 clamp 2->6");

    // R5 back-to-back on in-flight pulse
    do_reset();
    cfg_wait = 4'd7;
    fork
      begin send_qw(QA, 1'b1); send_qw(QB, 1'b0); end
      begin @(negedge clk); rdy = 1'b1; rdy_pulse(); end
    join
    wait_bytes(32);
    chk("R5 gap", start_q[1] - end_q[0], 1);
    chk("R5 queue drained", exp_q.size(), 0);

    // R6 no pulse: back to idle, full wait again
    do_reset();
    cfg_wait = 4'd6;
    @(negedge clk); rdy = 1'b1;
    send_qw(QA, 1'b0);
    send_qw(QB, 1'b0);
    wait_bytes(32);
    chk("R6 gap", start_q[1] - end_q[0], 8);
    chk("R6 queue drained", exp_q.size(), 0);

    // R7 permit held without data
    do_reset();
    cfg_wait = 4'd6;
    fork
      send_qw(QA, 1'b0);
      begin @(negedge clk); rdy = 1'b1; rdy_pulse(); end
    join
    wait_bytes(16);
    repeat (5) @(negedge clk);
    chk("R7 ready held", int'(qw_ready), 1);
    chk("R7 lclk idle", int'(lclk), 0);
    chk("R7 ldat idle", int'(ldat), 0);
    send_qw(QB, 1'b0);
    wait_bytes(32);
    chk("R7 start after accept", start_q[1] - sent_cyc, 1);
    chk("R7 queue drained", exp_q.size(), 0);

    // R8 invalid mode flag
    @(negedge clk); cfg_mode = 3'b101;
    @(negedge clk); chk("R8 101", int'(mode_err), 1);
    cfg_mode = 3'b111;
    @(negedge clk); chk("R8 111", int'(mode_err), 0);
    cfg_mode = 3'b001;
    @(negedge clk); chk("R8 001", int'(mode_err), 0);
    cfg_mode = 3'b100;
    @(negedge clk); chk("R8 100", int'(mode_err), 0);

    // R9 clock source select
    cfg_clksrc = 1'b1;
    @(negedge clk); chk("R9 internal", int'(clk_int), 1);
    cfg_clksrc = 1'b0;
    @(negedge clk); chk("R9 external", int'(clk_int), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule